// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor with Arbitration Guard

This block sits beside a firmware-driven master on a shared two-wire bus that has a clock line and a data line. It samples both lines through synchronizers and finds START and STOP conditions on them. It keeps a sticky start-seen flag and a sticky stop-seen flag, and from these two flags it tells software when the bus may be claimed.

The block drives neither line high. Each line is pulled low or released through a direction control. Software asks for a low level with a hold input, and the block turns that request into an output-enable. While the local master is active, the block compares the sensed data level with the released level on each rising clock edge of the bus. On a mismatch it records a lost arbitration, notes whether the loss fell in the address phase or in the data phase, and releases both lines at once.

A single interrupt flag gathers the START, STOP and byte-complete events. It stays set until software clears it.

Top module: `tw_bus_guard`

## Requirements
- R1: Reset clears start_seen, stop_seen, irq_flag, arb_lost and arb_in_addr. After reset, bus_free reads 1 and both output-enables read 0.
- R2: A START is sda_in falling while scl_in is high. It sets start_seen to 1 and clears stop_seen to 0. A STOP is sda_in rising while scl_in is high. It sets stop_seen to 1 and clears start_seen to 0. Both flags settle within 6 clock cycles of the line change. Clock-line changes and data changes while scl_in is low change neither flag.
- R3: bus_free is 1 exactly when stop_seen is 1, or when start_seen and stop_seen are both 0.
- R4: irq_flag is set by a START, by a STOP, and by a one-cycle pulse on byte_done. It stays set until a cycle with irq_clear high. If a set event and irq_clear fall in the same cycle, the flag is set.
- R5: irq is irq_flag AND irq_en. If software clears the flag and sets irq_en while the bus is busy, irq stays 0 during data bits and rises at the next STOP.
- R6: With enable high and no lost arbitration, scl_oe follows scl_hold and sda_oe follows sda_hold. A 1 on an output-enable drives that line low. A 0 releases the line, and the external pull-up then gives a 1.
- R7: Arbitration is lost when the synchronized clock line rises while master_active is 1, sda_hold is 0 and the synchronized data line is 0. Data-line changes while the clock line is low have no effect, and no loss is taken while sda_hold is 1.
- R8: While arb_lost is 1, scl_oe and sda_oe are both 0, whatever scl_hold and sda_hold request.
- R9: When arbitration is lost, arb_in_addr takes the value of phase_addr (1 = address phase, 0 = data phase). arb_lost and arb_in_addr stay unchanged through data bits and STOP conditions. The next START clears both to 0.
- R10: While enable is 0, start_seen, stop_seen, arb_lost and both output-enables are 0. Bus conditions and byte_done pulses are ignored, so irq_flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Block enable; 0 clears the flags and releases both lines |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| scl_hold | input | 1 | Software request to pull the clock line low |
| sda_hold | input | 1 | Software request to pull the data line low |
| master_active | input | 1 | Local master is transmitting; turns on the arbitration check |
| phase_addr | input | 1 | 1 while the address byte is being sent, 0 during data |
| byte_done | input | 1 | One-cycle pulse when a byte transmit or receive completes |
| irq_clear | input | 1 | One-cycle software clear of irq_flag |
| irq_en | input | 1 | Interrupt enable |
| scl_oe | output | 1 | Clock-line driver enable (1 = drive low) |
| sda_oe | output | 1 | Data-line driver enable (1 = drive low) |
| start_seen | output | 1 | A START was the most recent condition |
| stop_seen | output | 1 | A STOP was the most recent condition |
| bus_free | output | 1 | The bus may be claimed |
| irq_flag | output | 1 | Sticky interrupt event flag |
| irq | output | 1 | Interrupt request |
| arb_lost | output | 1 | Sticky arbitration-loss indication |
| arb_in_addr | output | 1 | Phase in which arbitration was lost (1 = address) |

## Verification
The bench builds the block with the default two synchronizer stages for both the bus lines and the reset. It lets every line change settle for six cycles, so the same checks also hold for a three-stage build. A wired-AND model of the bus feeds the output-enables back into scl_in and sda_in. This lets the bench check that a local low request really pulls the line down, and lets it create a true arbitration collision with an external master. Random sequences of START, STOP, data bits, byte completions and clears run alongside directed collision, phase, disable and set-versus-clear cases.

// File: rtl/tw_pkg.sv
package tw_pkg;

  // Bus events seen on one clock cycle after synchronization.
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } tw_events_t;

  // Transfer phase reported with an arbitration loss.
  typedef enum logic {
    PH_DATA = 1'b0,
    PH_ADDR = 1'b1
  } tw_phase_e;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int   STAGES  = 2,
  parameter int   WIDTH   = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {(STAGES*WIDTH){RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               scl_s,
  input  logic               sda_s,
  output tw_pkg::tw_events_t ev
);

  logic scl_prev_q, sda_prev_q;
  logic scl_prev_d, sda_prev_d;

  // The history registers run even while disabled, so that turning
  // the block on never shows a false edge.
  always_comb begin
    scl_prev_d = scl_s;
    sda_prev_d = sda_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_prev_d;
      sda_prev_q <= sda_prev_d;
    end
  end

  always_comb begin
    ev.start    = enable & scl_prev_q & scl_s &  sda_prev_q & ~sda_s;
    ev.stop     = enable & scl_prev_q & scl_s & ~sda_prev_q &  sda_s;
    ev.scl_rise = enable & ~scl_prev_q & scl_s;
  end

endmodule

// File: rtl/tw_arbiter.sv
module tw_arbiter (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  tw_pkg::tw_events_t ev,
  input  logic               sda_s,
  input  logic               master_active,
  input  logic               sda_hold,
  input  logic               phase_addr,
  output logic               arb_lost,
  output logic               arb_in_addr
);

  import tw_pkg::*;

  logic      lost_q, lost_d;
  tw_phase_e phase_q, phase_d;
  logic      mismatch;

  // The line was released expecting high but reads low on a clock rise.
  assign mismatch = ev.scl_rise & master_active & ~sda_hold & ~sda_s;

  always_comb begin
    lost_d  = lost_q;
    phase_d = phase_q;
    if (!enable) begin
      lost_d  = 1'b0;
      phase_d = PH_DATA;
    end else if (ev.start) begin
      lost_d  = 1'b0;
      phase_d = PH_DATA;
    end else if (!lost_q && mismatch) begin
      lost_d  = 1'b1;
      phase_d = phase_addr ? PH_ADDR : PH_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q  <= 1'b0;
      phase_q <= PH_DATA;
    end else begin
      lost_q  <= lost_d;
      phase_q <= phase_d;
    end
  end

  assign arb_lost    = lost_q;
  assign arb_in_addr = (phase_q == PH_ADDR);

endmodule

// File: rtl/tw_event_flags.sv
module tw_event_flags (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  tw_pkg::tw_events_t ev,
  input  logic               byte_done,
  input  logic               irq_clear,
  output logic               start_seen,
  output logic               stop_seen,
  output logic               irq_flag
);

  logic start_q, start_d;
  logic stop_q,  stop_d;
  logic irq_q,   irq_d;
  logic irq_set;

  assign irq_set = enable & (ev.start | ev.stop | byte_done);

  always_comb begin
    start_d = start_q;
    stop_d  = stop_q;
    if (!enable) begin
      start_d = 1'b0;
      stop_d  = 1'b0;
    end else if (ev.start) begin
      start_d = 1'b1;
      stop_d  = 1'b0;
    end else if (ev.stop) begin
      start_d = 1'b0;
      stop_d  = 1'b1;
    end
  end

  // A new event wins over a software clear in the same cycle.
  always_comb begin
    irq_d = irq_q;
    if (irq_set) begin
      irq_d = 1'b1;
    end else if (irq_clear) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
      irq_q   <= irq_d;
    end
  end

  assign start_seen = start_q;
  assign stop_seen  = stop_q;
  assign irq_flag   = irq_q;

endmodule

// File: rtl/tw_bus_guard.sv
module tw_bus_guard #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_in,
  input  logic sda_in,
  input  logic scl_hold,
  input  logic sda_hold,
  input  logic master_active,
  input  logic phase_addr,
  input  logic byte_done,
  input  logic irq_clear,
  input  logic irq_en,
  output logic scl_oe,
  output logic sda_oe,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free,
  output logic irq_flag,
  output logic irq,
  output logic arb_lost,
  output logic arb_in_addr
);

  import tw_pkg::*;

  localparam int LINES = 2;

  logic             rst_core_n;
  logic [LINES-1:0] lines_s;
  logic             scl_s, sda_s;
  tw_events_t       ev;
  logic             start_evt;

  tw_sync #(.STAGES(RST_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  tw_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES), .RST_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({scl_in, sda_in}),
    .q     (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  tw_cond_detect u_detect (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .enable (enable),
    .scl_s  (scl_s),
    .sda_s  (sda_s),
    .ev     (ev)
  );

  assign start_evt = ev.start;

  tw_arbiter u_arb (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .enable        (enable),
    .ev            (ev),
    .sda_s         (sda_s),
    .master_active (master_active),
    .sda_hold      (sda_hold),
    .phase_addr    (phase_addr),
    .arb_lost      (arb_lost),
    .arb_in_addr   (arb_in_addr)
  );

  tw_event_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .enable     (enable),
    .ev         (ev),
    .byte_done  (byte_done),
    .irq_clear  (irq_clear),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .irq_flag   (irq_flag)
  );

  // The data level is always low; only the direction is steered.
  assign scl_oe   = enable & scl_hold & ~arb_lost;
  assign sda_oe   = enable & sda_hold & ~arb_lost;
  assign bus_free = stop_seen | ~(start_seen | stop_seen);
  assign irq      = irq_flag & irq_en;

endmodule

// File: rtl/tw_bus_guard_chk.sv
module tw_bus_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic start_evt,
  input logic start_seen,
  input logic stop_seen,
  input logic bus_free,
  input logic irq_flag,
  input logic irq_clear,
  input logic arb_lost,
  input logic scl_oe,
  input logic sda_oe
);

  // R2
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));

  // R3
  busy_not_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |-> !bus_free);

  // R4
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clear) |=> irq_flag);

  // R8
  lines_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (!scl_oe && !sda_oe));

  // R9
  arb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !start_evt && enable) |=> arb_lost);

  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_seen && !stop_seen && !arb_lost));

endmodule

bind tw_bus_guard tw_bus_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .start_evt  (start_evt),
  .start_seen (start_seen),
  .stop_seen  (stop_seen),
  .bus_free   (bus_free),
  .irq_flag   (irq_flag),
  .irq_clear  (irq_clear),
  .arb_lost   (arb_lost),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe)
);

// File: tb/tw_bus_guard_test.sv
`timescale 1ns/1ps
module tw_bus_guard_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic scl_hold = 1'b0, sda_hold = 1'b0;
  logic master_active = 1'b0, phase_addr = 1'b0;
  logic byte_done = 1'b0, irq_clear = 1'b0, irq_en = 1'b0;
  logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic scl_line, sda_line;
  logic scl_oe, sda_oe, start_seen, stop_seen, bus_free, irq_flag, irq;
  logic arb_lost, arb_in_addr;

  int checks = 0;
  int errors = 0;
  int unsigned seed_dummy;

  bit m_start, m_stop, m_irq;
  bit cur_scl = 1'b1, cur_sda = 1'b1;

  always #4 clk = ~clk;

  // Wired-AND bus with pull-ups.
  assign scl_line = ~(scl_oe | ext_scl_low);
  assign sda_line = ~(sda_oe | ext_sda_low);

  tw_bus_guard uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_hold(scl_hold), .sda_hold(sda_hold),
    .master_active(master_active), .phase_addr(phase_addr),
    .byte_done(byte_done), .irq_clear(irq_clear), .irq_en(irq_en),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .start_seen(start_seen), .stop_seen(stop_seen), .bus_free(bus_free),
    .irq_flag(irq_flag), .irq(irq),
    .arb_lost(arb_lost), .arb_in_addr(arb_in_addr)
  );

  function automatic bit exp_free(bit s, bit p);
    return p | ~(s | p);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(bit scl, bit sda);
    ext_scl_low = !scl;
    ext_sda_low = !sda;
    cur_scl = scl;
    cur_sda = sda;
    settle();
  endtask

  task automatic go_start();
    drive(1'b0, cur_sda);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    if (enable) begin
      m_start = 1'b1; m_stop = 1'b0; m_irq = 1'b1;
    end
  endtask

  task automatic go_stop();
    drive(1'b0, cur_sda);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    if (enable) begin
      m_start = 1'b0; m_stop = 1'b1; m_irq = 1'b1;
    end
  endtask

  task automatic data_bit(bit b);
    drive(1'b0, cur_sda);
    drive(1'b0, b);
    drive(1'b1, b);
  endtask

  task automatic pulse(bit bd, bit clr);
    byte_done = bd;
    irq_clear = clr;
    @(negedge clk);
    byte_done = 1'b0;
    irq_clear = 1'b0;
    if (bd && enable) m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
  endtask

  task automatic check_flags(string tag);
    chk({tag, " start_seen"}, start_seen, m_start);
    chk({tag, " stop_seen"},  stop_seen,  m_stop);
    chk({tag, " bus_free"},   bus_free,   exp_free(m_start, m_stop));
    chk({tag, " irq_flag"},   irq_flag,   m_irq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd5150);
    m_start = 0; m_stop = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    check_flags("R1 reset");
    chk("R1 arb_lost", arb_lost, 1'b0);
    chk("R1 arb_in_addr", arb_in_addr, 1'b0);
    chk("R1 scl_oe", scl_oe, 1'b0);
    chk("R1 sda_oe", sda_oe, 1'b0);
    enable = 1'b1;
    settle();

    // R6 open-drain drive through direction control
    scl_hold = 1'b1;
    #1;
    chk("R6 scl_oe", scl_oe, 1'b1);
    chk("R6 scl line low", scl_line, 1'b0);
    chk("R6 sda released", sda_line, 1'b1);
    scl_hold = 1'b0;
    sda_hold = 1'b1;
    #1;
    chk("R6 sda_oe", sda_oe, 1'b1);
    sda_hold = 1'b0;
    settle();

    // R2 / R3 directed START then STOP
    go_start();
    check_flags("R2 after start");
    data_bit(1'b0);
    data_bit(1'b1);
    check_flags("R2 data bits no change");
    go_stop();
    check_flags("R3 after stop");

    // R4 set wins over clear
    pulse(1'b0, 1'b1);
    chk("R4 cleared", irq_flag, 1'b0);
    pulse(1'b1, 1'b1);
    chk("R4 set wins", irq_flag, 1'b1);
    pulse(1'b0, 1'b1);
    chk("R4 clear", irq_flag, 1'b0);

    // R5 enable while busy fires on the next STOP
    go_start();
    pulse(1'b0, 1'b1);
    irq_en = 1'b1;
    #1;
    chk("R5 busy irq low", irq, 1'b0);
    data_bit(1'b1);
    data_bit(1'b0);
    chk("R5 still low after bits", irq, 1'b0);
    go_stop();
    chk("R5 irq at stop", irq, 1'b1);
    irq_en = 1'b0;
    pulse(1'b0, 1'b1);

    // R7 collision in the address phase
    go_start();
    master_active = 1'b1;
    phase_addr = 1'b1;
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    chk("R7 low during scl low ignored", arb_lost, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    chk("R7 match no loss", arb_lost, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    chk("R7 loss", arb_lost, 1'b1);
    chk("R9 address phase", arb_in_addr, 1'b1);
    // R8 both lines released
    scl_hold = 1'b1;
    sda_hold = 1'b1;
    #1;
    chk("R8 scl_oe", scl_oe, 1'b0);
    chk("R8 sda_oe", sda_oe, 1'b0);
    scl_hold = 1'b0;
    sda_hold = 1'b0;
    master_active = 1'b0;
    go_stop();
    chk("R9 sticky over stop", arb_lost, 1'b1);
    go_start();
    chk("R9 cleared by start", arb_lost, 1'b0);
    chk("R9 phase cleared", arb_in_addr, 1'b0);

    // R7 no loss while driving low; data-phase loss
    master_active = 1'b1;
    phase_addr = 1'b0;
    drive(1'b0, 1'b1);
    sda_hold = 1'b1;
    drive(1'b1, 1'b1);
    chk("R7 driving low no loss", arb_lost, 1'b0);
    drive(1'b0, 1'b1);
    sda_hold = 1'b0;
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    chk("R7 data loss", arb_lost, 1'b1);
    chk("R9 data phase", arb_in_addr, 1'b0);
    master_active = 1'b0;
    go_start();
    go_stop();
    pulse(1'b0, 1'b1);

    // R10 disabled block
    go_start();
    pulse(1'b0, 1'b1);
    enable = 1'b0;
    m_start = 0; m_stop = 0;
    settle();
    check_flags("R10 disabled clear");
    go_stop();
    go_start();
    pulse(1'b1, 1'b0);
    check_flags("R10 ignored while disabled");
    scl_hold = 1'b1;
    #1;
    chk("R10 scl_oe off", scl_oe, 1'b0);
    scl_hold = 1'b0;
    enable = 1'b1;
    settle();
    check_flags("R10 re-enabled");

    // R2 R3 R4 random sequences
    for (int i = 0; i < 300; i++) begin
      int unsigned op;
      op = $urandom % 6;
      case (op)
        0: go_start();
        1: go_stop();
        2: data_bit(1'(($urandom % 2)));
        3: pulse(1'b1, 1'b0);
        4: pulse(1'b0, 1'b1);
        default: pulse(1'(($urandom % 2)), 1'b1);
      endcase
      check_flags("R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule